// File: doc/BRIEF.md
# Strobe-Timed Power-Down Controller

This block keeps track of the power state of a serial converter. It does this by timing the convert-start strobe against the serial clock, and by watching the select input. The strobe idles high. A strobe cycle begins when the strobe goes low. The block then counts rising serial-clock edges until the strobe goes high again. The edge count at that release decides what happens:

- A release inside a middle window is a power-down request. The first request puts the block in partial power-down. A second request from partial power-down moves it to full power-down.
- A late release is an ordinary conversion cycle. It brings the block back to active operation.
- A very early release is ignored.

Holding the select input high forces full power-down. Lowering it again wakes the block. After any wake-up from full power-down, the conversion-allowed flag stays low for a fixed number of system clocks so that the reference can settle.

All inputs are assumed to be synchronous to the system clock, which runs much faster than the serial clock. The outputs are the encoded power state, a reference-enable signal and the conversion-allowed flag.

Top module: `pdc_strobe_power`

## Requirements
- R1: A strobe fall clears the edge count. Each rising serial-clock edge while the strobe is low adds one, saturating at 2^CNT_W-1. A release with a count of 0, 1 or 2 leaves the power state unchanged.
- R2: The power state encoding is active = 2'b00, partial = 2'b01 and full = 2'b10. A release with a count from 3 to 13 while active moves the state to partial one cycle after the release.
- R3: A release with a count from 3 to 13 while in partial moves the state to full. Any release with a count of 13 or less while in full leaves the state at full.
- R4: A release with a count of 14 or more while in partial returns the state to active, and conv_ok is high in that same cycle.
- R5: A release with a count of 14 or more while in full returns the state to active. conv_ok then stays low for SETTLE_CYC cycles and rises on the next one.
- R6: ref_en equals ref_int while the state is active or partial, and is low while the state is full.
- R7: sel_n high puts the state in full on the next cycle. While sel_n stays high, strobe releases have no effect, and sel_n high overrides a release in the same cycle.
- R8: A falling sel_n while the state is full returns the state to active with the settling delay of R5. A strobe release in that same cycle is ignored.
- R9: After reset the state is active and conv_ok is low for SETTLE_CYC cycles. conv_ok is high only when the state is active and no settling delay is running.
- R10: A release with a count of 14 or more while active leaves the state at active and conv_ok high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled on clk |
| strobe | input | 1 | Convert-start strobe, idle high |
| sel_n | input | 1 | Select, high forces full power-down |
| ref_int | input | 1 | High when the internal reference is selected |
| pwr_state | output | 2 | 00 active, 01 partial, 10 full |
| ref_en | output | 1 | Reference enable |
| conv_ok | output | 1 | Conversions allowed |

## Verification
A strobe release can fall in the same cycle as a change of the select input, so two state changes compete for one cycle. The bench provokes this in two ways:

- It raises sel_n together with a power-down release while active. The expected result is full, with the release overridden.
- It lowers sel_n together with a release while held in full. The expected result is active with settling running, and the release is ignored.

Edge counts from 0 to 16 are swept from both the active and the partial state, so that each window boundary is covered. The end of the settling count is judged one cycle before and one cycle at expiry.

// File: rtl/pdc_pkg.sv
// Shared types for the strobe-timed power-down controller.
package pdc_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'b00,
        PS_PARTIAL = 2'b01,
        PS_FULL    = 2'b10
    } pwr_state_t;
endpackage

// File: rtl/pdc_edge_tracker.sv
// Counts rising serial-clock edges inside a strobe-low interval and classifies
// the strobe release by that count.
// Assumes sclk and strobe are synchronous to clk and slower than clk.
module pdc_edge_tracker #(
    parameter int CNT_W = 4,
    parameter int PD_LO = 3,
    parameter int PD_HI = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic strobe,
    output logic rel_pd,
    output logic rel_norm
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LO_V    = CNT_W'(PD_LO);
    localparam logic [CNT_W-1:0] HI_V    = CNT_W'(PD_HI);

    logic             sclk_q, strb_q;
    logic [CNT_W-1:0] cnt;
    logic             sclk_rise, strb_fall, strb_rise;

    assign sclk_rise = sclk & ~sclk_q;
    assign strb_fall = ~strobe & strb_q;
    assign strb_rise = strobe & ~strb_q;

    // Edge history and saturating edge count within a strobe-low interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            strb_q <= 1'b1;
            cnt    <= '0;
        end else begin
            sclk_q <= sclk;
            strb_q <= strobe;
            if (strb_fall)
                cnt <= sclk_rise ? CNT_W'(1) : '0;
            else if (!strobe && sclk_rise && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    // Release classification from the count held at the release.
    always_comb begin
        rel_pd   = strb_rise && (cnt >= LO_V) && (cnt <= HI_V);
        rel_norm = strb_rise && (cnt > HI_V);
    end
endmodule

// File: rtl/pdc_power_fsm.sv
// Power-state sequencer: active, partial and full power-down.
// Assumes at most one release pulse per cycle. Select overrides releases.
module pdc_power_fsm
    import pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       rel_pd,
    input  logic       rel_norm,
    output pwr_state_t state,
    output logic       wake
);
    pwr_state_t nxt;
    logic       sel_q;

    // Next-state decode: select first, then release-driven moves.
    always_comb begin
        nxt = state;
        if (sel_n)
            nxt = PS_FULL;
        else if (sel_q && state == PS_FULL)
            nxt = PS_ACTIVE;
        else begin
            unique case (state)
                PS_ACTIVE:  if (rel_pd) nxt = PS_PARTIAL;
                PS_PARTIAL: if (rel_pd) nxt = PS_FULL;
                            else if (rel_norm) nxt = PS_ACTIVE;
                PS_FULL:    if (rel_norm) nxt = PS_ACTIVE;
                default:    nxt = PS_ACTIVE;
            endcase
        end
    end

    // Wake-up pulse marks leaving full power-down toward active.
    assign wake = (state == PS_FULL) && (nxt == PS_ACTIVE);

    // State and select history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_ACTIVE;
            sel_q <= 1'b0;
        end else begin
            state <= nxt;
            sel_q <= sel_n;
        end
    end
endmodule

// File: rtl/pdc_settle_timer.sv
// Reference settling timer. Load starts a SETTLE_CYC countdown and hold
// keeps it cleared. Reset starts a countdown. Assumes SETTLE_CYC >= 1.
module pdc_settle_timer #(
    parameter int SETTLE_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic hold,
    output logic done
);
    localparam int            TW     = $clog2(SETTLE_CYC + 1);
    localparam logic [TW-1:0] LOAD_V = TW'(SETTLE_CYC);

    logic [TW-1:0] cnt;

    // Countdown with load priority over hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= LOAD_V;
        else if (load)
            cnt <= LOAD_V;
        else if (hold)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pdc_strobe_power.sv
// Top of the strobe-timed power-down controller.
// Assumes all inputs are synchronous to clk.
module pdc_strobe_power
    import pdc_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int PD_LO      = 3,
    parameter int PD_HI      = 13,
    parameter int SETTLE_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       strobe,
    input  logic       sel_n,
    input  logic       ref_int,
    output logic [1:0] pwr_state,
    output logic       ref_en,
    output logic       conv_ok
);
    logic       rel_pd, rel_norm, wake, settled;
    pwr_state_t state;

    pdc_edge_tracker #(.CNT_W(CNT_W), .PD_LO(PD_LO), .PD_HI(PD_HI)) i_edges (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .strobe(strobe),
        .rel_pd(rel_pd), .rel_norm(rel_norm)
    );

    pdc_power_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rel_pd(rel_pd),
        .rel_norm(rel_norm), .state(state), .wake(wake)
    );

    pdc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
        .clk(clk), .rst_n(rst_n), .load(wake), .hold(state == PS_FULL),
        .done(settled)
    );

    // Output decode from state and settling status.
    always_comb begin
        pwr_state = state;
        ref_en    = ref_int && (state != PS_FULL);
        conv_ok   = (state == PS_ACTIVE) && settled;
    end
endmodule

// File: rtl/pdc_strobe_power_chk.sv
// Property checker for pdc_strobe_power, attached with bind below.
module pdc_strobe_power_chk
    import pdc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n,
    input logic [1:0] pwr_state,
    input logic       ref_en,
    input logic       conv_ok,
    input logic       rel_pd,
    input logic       rel_norm
);
    a_r1_release_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_pd && rel_norm));
    a_r2_active_to_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && pwr_state == PS_ACTIVE && rel_pd) |=> pwr_state == PS_PARTIAL);
    a_r3_partial_to_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && pwr_state == PS_PARTIAL && rel_pd) |=> pwr_state == PS_FULL);
    a_r4_partial_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && pwr_state == PS_PARTIAL && rel_norm) |=> pwr_state == PS_ACTIVE);
    a_r5_wake_blocks_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_ACTIVE && $past(pwr_state) == PS_FULL) |-> !conv_ok);
    a_r6_ref_off_in_full: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_FULL) |-> !ref_en);
    a_r7_select_forces_full: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> pwr_state == PS_FULL);
    a_r9_conv_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ok |-> pwr_state == PS_ACTIVE);
endmodule

bind pdc_strobe_power pdc_strobe_power_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .pwr_state(pwr_state),
    .ref_en(ref_en), .conv_ok(conv_ok), .rel_pd(rel_pd), .rel_norm(rel_norm)
);

// File: tb/test_pdc_strobe_power.sv
`timescale 1ns/1ps
module test_pdc_strobe_power;
    localparam int S = 12;
    localparam logic [1:0] ACT = 2'b00, PAR = 2'b01, FUL = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, strobe = 1'b1;
    logic sel_n = 1'b0, ref_int = 1'b1;
    logic [1:0] pwr_state;
    logic ref_en, conv_ok;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    pdc_strobe_power #(.CNT_W(4), .PD_LO(3), .PD_HI(13), .SETTLE_CYC(S)) i_pdc_strobe_power (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .strobe(strobe), .sel_n(sel_n),
        .ref_int(ref_int), .pwr_state(pwr_state), .ref_en(ref_en), .conv_ok(conv_ok)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; tick();
        sclk = 1'b0; tick();
    endtask

    // One strobe cycle with n edges. The select level is applied with the release.
    task automatic strobe_cycle_sel(input int n, input logic sel_at_rel);
        strobe = 1'b0; tick(); tick();
        for (int i = 0; i < n; i++) sclk_pulse();
        strobe = 1'b1; sel_n = sel_at_rel; tick();
    endtask

    task automatic strobe_cycle(input int n);
        strobe_cycle_sel(n, sel_n);
    endtask

    task automatic to_active();
        if (pwr_state == FUL) begin
            strobe_cycle(14);
            repeat (S) tick();
        end else if (pwr_state == PAR) begin
            strobe_cycle(14);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) tick();
        check("R9 reset state", pwr_state, ACT);
        check("R9 reset conv_ok", conv_ok, 0);
        check("R6 reset ref_en", ref_en, 1);
        rst_n = 1'b1;
        repeat (S - 1) tick();
        check("R9 settle not yet", conv_ok, 0);
        tick();
        check("R9 settle done", conv_ok, 1);

        // Sweep of edge counts from active.
        for (int n = 0; n <= 16; n++) begin
            strobe_cycle(n);
            if (n >= 3 && n <= 13) check("R2 active pd window", pwr_state, PAR);
            else if (n < 3) check("R1 short release ignored", pwr_state, ACT);
            else begin
                check("R10 normal from active", pwr_state, ACT);
                check("R10 conv_ok kept", conv_ok, 1);
            end
            to_active();
        end

        // Sweep of edge counts from partial.
        for (int n = 0; n <= 16; n++) begin
            strobe_cycle(5);
            check("R6 ref_en in partial", ref_en, 1);
            strobe_cycle(n);
            if (n < 3) check("R1 short ignored in partial", pwr_state, PAR);
            else if (n <= 13) begin
                check("R3 partial to full", pwr_state, FUL);
                check("R6 ref_en off in full", ref_en, 0);
            end else begin
                check("R4 partial to active", pwr_state, ACT);
                check("R4 no settle wait", conv_ok, 1);
            end
            to_active();
        end

        // Full power-down: non-normal releases keep it, normal wakes with settling.
        strobe_cycle(3); strobe_cycle(13);
        check("R3 full by sequence", pwr_state, FUL);
        strobe_cycle(2);  check("R3 full kept n=2", pwr_state, FUL);
        strobe_cycle(3);  check("R3 full kept n=3", pwr_state, FUL);
        strobe_cycle(13); check("R3 full kept n=13", pwr_state, FUL);
        strobe_cycle(14);
        check("R5 wake to active", pwr_state, ACT);
        check("R5 conv blocked", conv_ok, 0);
        repeat (S - 1) tick();
        check("R5 conv blocked last", conv_ok, 0);
        tick();
        check("R5 conv allowed", conv_ok, 1);

        // External reference selected.
        ref_int = 1'b0;
        tick(); check("R6 ref_en active ext", ref_en, 0);
        strobe_cycle(7); check("R6 ref_en partial ext", ref_en, 0);
        to_active();
        ref_int = 1'b1;

        // Select-forced power-down.
        sel_n = 1'b1; tick();
        check("R7 select forces full", pwr_state, FUL);
        check("R7 ref_en off", ref_en, 0);
        strobe_cycle(14); check("R7 normal ignored", pwr_state, FUL);
        strobe_cycle(5);  check("R7 pd ignored", pwr_state, FUL);
        sel_n = 1'b0; tick();
        check("R8 select exit", pwr_state, ACT);
        check("R8 conv blocked", conv_ok, 0);
        repeat (S - 1) tick();
        check("R8 conv blocked last", conv_ok, 0);
        tick();
        check("R8 conv allowed", conv_ok, 1);

        // Select from partial.
        strobe_cycle(4);
        sel_n = 1'b1; tick(); check("R7 partial to full", pwr_state, FUL);
        sel_n = 1'b0; tick(); check("R8 exit from partial", pwr_state, ACT);
        repeat (S) tick();
        check("R8 settled", conv_ok, 1);

        // Coincidence: select rises with a pd release.
        strobe_cycle_sel(5, 1'b1);
        check("R7 select beats release", pwr_state, FUL);
        // Coincidence: select falls with a pd release.
        strobe_cycle_sel(5, 1'b0);
        check("R8 select exit beats release", pwr_state, ACT);
        check("R8 conv blocked coincident", conv_ok, 0);
        repeat (S) tick();
        check("R8 settled coincident", conv_ok, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule